// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This combinational unit sits between a 32-bit register datapath and a word-indexed data memory. From a base register value and a 16-bit signed offset it forms the effective byte address and turns it into a word index for the memory. For stores, it places the source register's data on the correct byte lanes and produces a per-lane write mask. For loads, it picks the addressed byte or halfword out of the word read from memory, then zero-extends or sign-extends it to 32 bits.

Lanes are little-endian. Lane k holds bits 8k+7 down to 8k of the memory word. Halfword accesses that are not on a 2-byte boundary, and word accesses that are not on a 4-byte boundary, are flagged as misaligned. When an access is misaligned, no lane is written and the load result is forced to zero.

Internally, a small control decoder turns the operation code and the low address bits into a struct of strobes: store, access size, sign extension and fault. The datapath holds the adder, the lane selection and the replication logic.

Top module: `lsu_lane_align`

## Requirements
- R1: `wordIdx` equals bits 31:2 of `baseReg` plus `offsetImm` sign-extended to 32 bits. The sum wraps modulo 2^32.
- R2: Operation code 0 (word load) returns `memRdata` unchanged on `loadResult`. Operation code 5 (word store) drives `storeWord` equal to `storeSrc` and `byteMask` equal to 4'b1111 when the address is aligned.
- R3: Operation code 4 (unsigned byte load) puts the lane selected by address bits 1:0 into `loadResult[7:0]` and zeros bits 31:8.
- R4: Operation code 3 (signed byte load) puts the selected lane into `loadResult[7:0]` and copies that byte's bit 7 into bits 31:8.
- R5: Operation code 2 (unsigned halfword load) puts the halfword selected by address bit 1 into `loadResult[15:0]` and zeros bits 31:16. Address bit 1 = 0 selects bits 15:0 of the memory word; address bit 1 = 1 selects bits 31:16.
- R6: Operation code 1 (signed halfword load) selects the halfword in the same way as R5 and copies its bit 15 into bits 31:16.
- R7: Operation code 7 (byte store) drives `byteMask` to one-hot bit `addr[1:0]` and replicates `storeSrc[7:0]` into all four lanes of `storeWord`.
- R8: Operation code 6 (halfword store) drives `byteMask` to 4'b0011 when address bit 1 is 0 and to 4'b1100 when it is 1. It drives `storeWord` to `storeSrc[15:0]` repeated twice.
- R9: `misalign` is 1 for a halfword operation with address bit 0 set, and for a word operation with address bits 1:0 nonzero. It is never 1 for a byte operation. While `misalign` is 1, `byteMask` is 0 and `loadResult` is 0.
- R10: Load operations (codes 0 to 4) always drive `byteMask` to 0. Store operations (codes 5 to 7) always drive `loadResult` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| baseReg | input | 32 | Base register value |
| offsetImm | input | 16 | Signed address offset |
| storeSrc | input | 32 | Register data to be stored |
| memRdata | input | 32 | Word read from memory |
| opSel | input | 3 | Operation code (see R2 to R8) |
| wordIdx | output | 30 | Memory word index |
| byteMask | output | 4 | Per-lane write enable |
| storeWord | output | 32 | Lane-replicated store data |
| loadResult | output | 32 | Extended load data |
| misalign | output | 1 | Misaligned access flag |

## Verification
The bench probes each byte lane and each halfword position with data whose top bit is set and with data whose top bit is clear. A design with the lanes in big-endian order, or one that extends with the wrong polarity, gives wrong high bits on these cases. Negative offsets and a base that wraps past 2^32 expose an offset that is zero-extended instead of sign-extended, or an adder with the wrong width. Misaligned halfword and word accesses are checked to leave the mask and the load result at zero, and byte accesses at odd addresses are checked to raise no flag. These cases catch a fault decode that is too broad or too narrow.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

  typedef enum logic [2:0] {
    OP_LW  = 3'd0,
    OP_LH  = 3'd1,
    OP_LHU = 3'd2,
    OP_LB  = 3'd3,
    OP_LBU = 3'd4,
    OP_SW  = 3'd5,
    OP_SH  = 3'd6,
    OP_SB  = 3'd7
  } memOp_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  // strobes handed from the decoder to the datapath
  typedef struct packed {
    logic     isStore;
    accSize_e size;
    logic     signExt;
    logic     fault;
  } laneCtl_t;

endpackage

// File: rtl/lsu_lane_ctrl.sv
module lsu_lane_ctrl
  import lsu_lane_pkg::*;
#(
  parameter int LANE_BITS = 2
) (
  input  logic [2:0]           opSel,
  input  logic [LANE_BITS-1:0] laneIdx,
  output laneCtl_t             ctl
);

  memOp_e op;
  assign op = memOp_e'(opSel);

  always_comb begin
    ctl = '{isStore: 1'b0, size: SZ_WORD, signExt: 1'b0, fault: 1'b0};
    unique case (op)
      OP_LW:  ctl.size = SZ_WORD;
      OP_LH:  begin ctl.size = SZ_HALF; ctl.signExt = 1'b1; end
      OP_LHU: ctl.size = SZ_HALF;
      OP_LB:  begin ctl.size = SZ_BYTE; ctl.signExt = 1'b1; end
      OP_LBU: ctl.size = SZ_BYTE;
      OP_SW:  begin ctl.size = SZ_WORD; ctl.isStore = 1'b1; end
      OP_SH:  begin ctl.size = SZ_HALF; ctl.isStore = 1'b1; end
      OP_SB:  begin ctl.size = SZ_BYTE; ctl.isStore = 1'b1; end
      default: ctl.size = SZ_WORD;
    endcase
    case (ctl.size)
      SZ_HALF: ctl.fault = laneIdx[0];
      SZ_WORD: ctl.fault = |laneIdx;
      default: ctl.fault = 1'b0;
    endcase
  end

  always_comb begin
    if (ctl.isStore) begin
      AST_STORE_NOT_SIGNED: assert (!ctl.signExt); // R10
    end
    if (opSel == 3'd7 || opSel == 3'd4 || opSel == 3'd3) begin
      AST_BYTE_NEVER_FAULTS: assert (!ctl.fault); // R9
    end
  end

endmodule

// File: rtl/lsu_lane_dp.sv
module lsu_lane_dp
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES     = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES),
  localparam int HALVES    = LANES / 2
) (
  input  logic [DATA_W-1:0]         baseReg,
  input  logic [OFF_W-1:0]          offsetImm,
  input  logic [DATA_W-1:0]         storeSrc,
  input  logic [DATA_W-1:0]         memRdata,
  input  laneCtl_t                  ctl,
  output logic [LANE_BITS-1:0]      laneIdx,
  output logic [DATA_W-LANE_BITS-1:0] wordIdx,
  output logic [LANES-1:0]          byteMask,
  output logic [DATA_W-1:0]         storeWord,
  output logic [DATA_W-1:0]         loadResult
);

  logic [DATA_W-1:0] offExt;
  logic [DATA_W-1:0] byteAddr;

  assign offExt   = {{(DATA_W-OFF_W){offsetImm[OFF_W-1]}}, offsetImm};
  assign byteAddr = baseReg + offExt;
  assign wordIdx  = byteAddr[DATA_W-1:LANE_BITS];
  assign laneIdx  = byteAddr[LANE_BITS-1:0];

  logic [LANE_BITS-2:0] halfIdx;
  assign halfIdx = laneIdx[LANE_BITS-1:1];

  // lane write enables
  logic writeOk;
  assign writeOk = ctl.isStore && !ctl.fault;

  for (genvar i = 0; i < LANES; i++) begin : gLaneMask
    localparam logic [LANE_BITS-1:0] LI = LANE_BITS'(i);
    logic hit;
    always_comb begin
      case (ctl.size)
        SZ_BYTE: hit = (laneIdx == LI);
        SZ_HALF: hit = (halfIdx == LI[LANE_BITS-1:1]);
        default: hit = 1'b1;
      endcase
    end
    assign byteMask[i] = writeOk && hit;
  end

  // store data replication
  always_comb begin
    case (ctl.size)
      SZ_BYTE: storeWord = {LANES{storeSrc[7:0]}};
      SZ_HALF: storeWord = {HALVES{storeSrc[15:0]}};
      default: storeWord = storeSrc;
    endcase
  end

  // load lane extraction
  logic [7:0]  laneByte [LANES];
  logic [15:0] laneHalf [HALVES];

  for (genvar i = 0; i < LANES; i++) begin : gByteLane
    assign laneByte[i] = memRdata[8*i +: 8];
  end
  for (genvar j = 0; j < HALVES; j++) begin : gHalfLane
    assign laneHalf[j] = memRdata[16*j +: 16];
  end

  logic [7:0]  pickByte;
  logic [15:0] pickHalf;
  assign pickByte = laneByte[laneIdx];
  assign pickHalf = laneHalf[halfIdx];

  always_comb begin
    if (ctl.isStore || ctl.fault) begin
      loadResult = '0;
    end else begin
      case (ctl.size)
        SZ_BYTE: loadResult = {{(DATA_W-8){ctl.signExt & pickByte[7]}}, pickByte};
        SZ_HALF: loadResult = {{(DATA_W-16){ctl.signExt & pickHalf[15]}}, pickHalf};
        default: loadResult = memRdata;
      endcase
    end
  end

  always_comb begin
    if (ctl.fault) begin
      AST_FAULT_NO_WRITE: assert (byteMask == '0); // R9
    end
    if (!ctl.isStore) begin
      AST_LOAD_NO_WRITE: assert (byteMask == '0); // R10
    end
    if (ctl.isStore) begin
      AST_STORE_NO_LOAD: assert (loadResult == '0); // R10
    end
    if (writeOk && ctl.size == SZ_BYTE) begin
      AST_BYTE_MASK_ONEHOT: assert ($countones(byteMask) == 1); // R7
      AST_BYTE_LANE_DATA: assert (storeWord[8*laneIdx +: 8] == storeSrc[7:0]); // R7
    end
    if (writeOk && ctl.size == SZ_HALF) begin
      AST_HALF_MASK_PAIR: assert ($countones(byteMask) == 2); // R8
    end
    if (!ctl.isStore && !ctl.fault && ctl.size == SZ_BYTE && ctl.signExt) begin
      AST_BYTE_SIGN_FILL: assert (loadResult[DATA_W-1:8] == {(DATA_W-8){loadResult[7]}}); // R4
    end
    if (!ctl.isStore && !ctl.fault && ctl.size == SZ_BYTE && !ctl.signExt) begin
      AST_BYTE_ZERO_FILL: assert (loadResult[DATA_W-1:8] == '0); // R3
    end
    if (!ctl.isStore && !ctl.fault && ctl.size == SZ_HALF && !ctl.signExt) begin
      AST_HALF_ZERO_FILL: assert (loadResult[DATA_W-1:16] == '0); // R5
    end
  end

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES     = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic [DATA_W-1:0]           baseReg,
  input  logic [OFF_W-1:0]            offsetImm,
  input  logic [DATA_W-1:0]           storeSrc,
  input  logic [DATA_W-1:0]           memRdata,
  input  logic [2:0]                  opSel,
  output logic [DATA_W-LANE_BITS-1:0] wordIdx,
  output logic [LANES-1:0]            byteMask,
  output logic [DATA_W-1:0]           storeWord,
  output logic [DATA_W-1:0]           loadResult,
  output logic                        misalign
);

  laneCtl_t             ctl;
  logic [LANE_BITS-1:0] laneIdx;

  lsu_lane_ctrl #(.LANE_BITS(LANE_BITS)) uCtrl (
    .opSel   (opSel),
    .laneIdx (laneIdx),
    .ctl     (ctl)
  );

  lsu_lane_dp #(.DATA_W(DATA_W), .OFF_W(OFF_W)) uDp (
    .baseReg    (baseReg),
    .offsetImm  (offsetImm),
    .storeSrc   (storeSrc),
    .memRdata   (memRdata),
    .ctl        (ctl),
    .laneIdx    (laneIdx),
    .wordIdx    (wordIdx),
    .byteMask   (byteMask),
    .storeWord  (storeWord),
    .loadResult (loadResult)
  );

  assign misalign = ctl.fault;

endmodule

// File: tb/tb_lsu_lane_align.sv
module tb_lsu_lane_align;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] baseReg, storeSrc, memRdata;
  logic [15:0] offsetImm;
  logic [2:0]  opSel;
  logic [29:0] wordIdx;
  logic [3:0]  byteMask;
  logic [31:0] storeWord, loadResult;
  logic        misalign;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_lane_align dut (
    .baseReg(baseReg), .offsetImm(offsetImm), .storeSrc(storeSrc),
    .memRdata(memRdata), .opSel(opSel), .wordIdx(wordIdx),
    .byteMask(byteMask), .storeWord(storeWord), .loadResult(loadResult),
    .misalign(misalign)
  );

  typedef struct packed {
    logic [31:0] b;
    logic [15:0] o;
    logic [31:0] s;
    logic [31:0] r;
    logic [2:0]  op;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 16'h0008, 32'h0, 32'hCAFE_F00D, 3'd0, 8'd2},  // R2 word load
    '{32'h0000_2000, 16'hFFF8, 32'h0, 32'h1234_5678, 3'd0, 8'd1},  // R1 negative offset
    '{32'h0000_0100, 16'h0000, 32'h0, 32'hA1B2_C3D4, 3'd4, 8'd3},  // R3 lane0
    '{32'h0000_0100, 16'h0001, 32'h0, 32'hA1B2_C3D4, 3'd4, 8'd3},  // R3 lane1
    '{32'h0000_0102, 16'h0000, 32'h0, 32'hA1B2_C3D4, 3'd4, 8'd3},  // R3 lane2
    '{32'h0000_0100, 16'h0003, 32'h0, 32'hA1B2_C3D4, 3'd4, 8'd3},  // R3 lane3
    '{32'h0000_0100, 16'h0001, 32'h0, 32'h0000_8000, 3'd3, 8'd4},  // R4 negative byte
    '{32'h0000_0100, 16'h0002, 32'h0, 32'h0070_0000, 3'd3, 8'd4},  // R4 positive byte
    '{32'h0000_0100, 16'h0002, 32'h0, 32'h9ABC_DEF0, 3'd2, 8'd5},  // R5 upper half
    '{32'h0000_0100, 16'h0000, 32'h0, 32'h9ABC_DEF0, 3'd2, 8'd5},  // R5 lower half
    '{32'h0000_0100, 16'h0000, 32'h0, 32'h1234_8001, 3'd1, 8'd6},  // R6 negative half
    '{32'h0000_0102, 16'h0000, 32'h0, 32'h7FFF_8001, 3'd1, 8'd6},  // R6 positive half
    '{32'h0000_0200, 16'h0004, 32'hDEAD_BEEF, 32'h0, 3'd5, 8'd2},  // R2 word store
    '{32'h0000_0200, 16'h0002, 32'h1122_3344, 32'h0, 3'd7, 8'd7},  // R7 byte lane2
    '{32'h0000_0203, 16'h0000, 32'h1122_3355, 32'h0, 3'd7, 8'd7},  // R7 byte lane3
    '{32'h0000_0200, 16'h0000, 32'h5566_7788, 32'h0, 3'd6, 8'd8},  // R8 lower half
    '{32'h0000_0200, 16'h0003, 32'h0, 32'h0, 3'd1, 8'd9},          // R9 odd half load
    '{32'h0000_0201, 16'h0000, 32'hFFFF_FFFF, 32'h0, 3'd5, 8'd9}   // R9 odd word store
  };

  // reference behaviour written from the requirements
  function automatic void model(input logic [31:0] b, input logic [15:0] o,
                                input logic [31:0] s, input logic [31:0] r,
                                input logic [2:0] op,
                                output logic [29:0] w, output logic [3:0] m,
                                output logic [31:0] sw, output logic [31:0] ld,
                                output logic mis);
    logic [31:0] ea;
    logic [7:0]  bt;
    logic [15:0] hw;
    ea  = b + {{16{o[15]}}, o};
    w   = ea[31:2];
    m   = 4'h0;
    sw  = 32'h0;
    ld  = 32'h0;
    mis = 1'b0;
    bt  = 8'(r >> (8 * ea[1:0]));
    hw  = ea[1] ? r[31:16] : r[15:0];
    case (op)
      3'd0: begin mis = (ea[1:0] != 2'b00); ld = r; end
      3'd1: begin mis = ea[0]; ld = {{16{hw[15]}}, hw}; end
      3'd2: begin mis = ea[0]; ld = {16'h0, hw}; end
      3'd3: ld = {{24{bt[7]}}, bt};
      3'd4: ld = {24'h0, bt};
      3'd5: begin mis = (ea[1:0] != 2'b00); sw = s; m = 4'hF; end
      3'd6: begin mis = ea[0]; sw = {s[15:0], s[15:0]}; m = ea[1] ? 4'b1100 : 4'b0011; end
      default: begin sw = {4{s[7:0]}}; m = 4'b0001 << ea[1:0]; end
    endcase
    if (mis) begin m = 4'h0; ld = 32'h0; end
  endfunction

  task automatic apply(input logic [31:0] b, input logic [15:0] o,
                       input logic [31:0] s, input logic [31:0] r, input logic [2:0] op);
    @(negedge clk);
    baseReg = b; offsetImm = o; storeSrc = s; memRdata = r; opSel = op;
    #(CLK_PERIOD/4);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkModel(input string tag, input logic [2:0] op);
    logic [29:0] w; logic [3:0] m; logic [31:0] sw, ld; logic mis;
    model(baseReg, offsetImm, storeSrc, memRdata, op, w, m, sw, ld, mis);
    chk({tag, " wordIdx"}, {2'b0, wordIdx}, {2'b0, w});
    chk({tag, " mask"}, {28'h0, byteMask}, {28'h0, m});
    chk({tag, " load"}, loadResult, ld);
    chk({tag, " misalign"}, {31'h0, misalign}, {31'h0, mis});
    if (op >= 3'd5) chk({tag, " storeWord"}, storeWord, sw);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    // idle state: all-zero inputs, word load at address 0 (R10, R9)
    apply(32'h0, 16'h0, 32'h0, 32'h0, 3'd0);
    chk("R10 idle mask", {28'h0, byteMask}, 32'h0);
    chk("R9 idle misalign", {31'h0, misalign}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].b, VECS[i].o, VECS[i].s, VECS[i].r, VECS[i].op);
      checkModel($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].op);
    end

    // R1 sign-extended offset: 0x1000_0000 - 4 -> word index 0x03FF_FFFF
    apply(32'h1000_0000, 16'hFFFC, 32'h0, 32'h0, 3'd0);
    chk("R1 neg offset", {2'b0, wordIdx}, 32'h03FF_FFFF);
    // R1 wrap past 2^32
    apply(32'hFFFF_FFFF, 16'h0001, 32'h0, 32'h0, 3'd0);
    chk("R1 wrap", {2'b0, wordIdx}, 32'h0);
    // R4 top lane with bit 7 set
    apply(32'h0000_0003, 16'h0, 32'h0, 32'h8011_2233, 3'd3);
    chk("R4 lane3 sign", loadResult, 32'hFFFF_FF80);
    // R3 same lane unsigned
    apply(32'h0000_0003, 16'h0, 32'h0, 32'h8011_2233, 3'd4);
    chk("R3 lane3 zero", loadResult, 32'h0000_0080);
    // R6 upper half negative
    apply(32'h0000_0002, 16'h0, 32'h0, 32'hF00D_0000, 3'd1);
    chk("R6 upper sign", loadResult, 32'hFFFF_F00D);
    // R8 upper half store
    apply(32'h0000_0002, 16'h0, 32'h1234_BEEF, 32'h0, 3'd6);
    chk("R8 mask", {28'h0, byteMask}, 32'h0000_000C);
    chk("R8 data", storeWord, 32'hBEEF_BEEF);
    // R7 odd address byte store is legal
    apply(32'h0000_0001, 16'h0, 32'h0000_00A5, 32'h0, 3'd7);
    chk("R7 mask", {28'h0, byteMask}, 32'h0000_0002);
    chk("R9 byte no flag", {31'h0, misalign}, 32'h0);
    chk("R7 data", storeWord, 32'hA5A5_A5A5);
    // R9 misaligned word load and word store
    apply(32'h0000_0002, 16'h0, 32'h0, 32'hFFFF_FFFF, 3'd0);
    chk("R9 word load flag", {31'h0, misalign}, 32'h1);
    chk("R9 word load zero", loadResult, 32'h0);
    apply(32'h0000_0002, 16'h0, 32'h1, 32'h0, 3'd5);
    chk("R9 word store mask", {28'h0, byteMask}, 32'h0);
    // R9 halfword store at odd address
    apply(32'h0000_0003, 16'h0, 32'hFFFF, 32'h0, 3'd6);
    chk("R9 half store mask", {28'h0, byteMask}, 32'h0);
    chk("R9 half store flag", {31'h0, misalign}, 32'h1);
    // R10 load leaves mask at zero; store leaves load result at zero
    apply(32'h0000_0000, 16'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd4);
    chk("R10 load mask", {28'h0, byteMask}, 32'h0);
    apply(32'h0000_0000, 16'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd7);
    chk("R10 store load", loadResult, 32'h0);
    // R2 aligned word store mask
    apply(32'h0000_0010, 16'h0, 32'h0BAD_CAFE, 32'h0, 3'd5);
    chk("R2 store mask", {28'h0, byteMask}, 32'h0000_000F);
    chk("R2 store data", storeWord, 32'h0BAD_CAFE);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule